// File: doc/BRIEF.md
# Vector Element Address Sequencer

This block turns one vector memory operation into a stream of per-element memory addresses. A single start pulse captures the operation's operands: base address, stride, addressing mode, transfer direction and the active vector length. From the next cycle on, the block emits one element address per accepted handshake, tagged with the element number, a final-element flag and the direction bit. A one-cycle completion pulse follows the last element.

Three addressing modes share one sequencer. Contiguous mode steps one element at a time. Strided mode steps by a scalar stride. Indexed mode adds a per-element offset to the base, and that offset is read from a vector register through a read port driven by the block. The same modes serve loads (gather) and stores (scatter), and the direction bit only travels alongside the addresses. Addresses are counted in elements and wrap modulo 2^AW. The stride is accumulated by addition each step, so no multiplier is needed.

Top module: `vec_agen`

## Requirements
- R1: With mode 2'b00 (contiguous; 2'b11 behaves the same), element i carries address base + i.
- R2: With mode 2'b01 (strided), element i carries address base + i*stride, computed modulo 2^AW, so sums past the top of the address space wrap.
- R3: With mode 2'b10 (indexed), the block drives idx_rd_addr with the current element number i and emits base + idx_rd_data, where idx_rd_data is combinationally element i of the offset vector.
- R4: Mode, base, stride, direction and length are captured on an accepted start. out_dir for every element equals the dir value seen at start, and later changes on these inputs have no effect on the running sequence.
- R5: Exactly VL addresses are emitted, with out_elem running 0..VL-1 in order, and out_last is high only on element VL-1.
- R6: The first element is valid in the cycle after start. done is high for exactly one cycle, the cycle after the final element's handshake, and it is never high together with out_valid.
- R7: While out_valid is high and out_ready is low, out_addr, out_elem and out_last hold their values.
- R8: A start pulse while a sequence is in progress is ignored, and the running sequence continues unchanged.
- R9: A start with VL = 0 emits no address and raises done in the next cycle.
- R10: A requested length above MVL is clamped to MVL elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| mode | input | 2 | 00 contiguous, 01 strided, 10 indexed, 11 contiguous |
| dir | input | 1 | Transfer direction (1 = store), carried with each address |
| base | input | AW | Base element address |
| stride | input | AW | Element stride for strided mode |
| vl | input | LW | Active vector length, LW = clog2(MVL+1) |
| idx_rd_addr | output | EW | Element number whose offset is requested, EW = clog2(MVL) |
| idx_rd_data | input | AW | Offset of element idx_rd_addr (combinational) |
| out_valid | output | 1 | Element address valid |
| out_ready | input | 1 | Consumer accepts the element address |
| out_addr | output | AW | Element address |
| out_elem | output | EW | Element number |
| out_last | output | 1 | Final element of the sequence |
| out_dir | output | 1 | Captured direction |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle the cycle-local rules: the element number and running address stay put during a stall, a start during a sequence leaves the captured operands untouched, a zero-length or final handshake is followed by done with no valid element, done and out_valid never overlap, the element number rises by one after each non-final handshake, and the captured length never exceeds MVL. Only the bench's scenarios can show that the address values are right for each mode, including wrap at the top of the address space and indexed offsets from a memory model. They also show the exact element count for a given length, the clamp of long requests, and that the direction and operands come from the start cycle and not from later input changes.

// File: rtl/vec_agen_pkg.sv
// Shared types for the vector element address sequencer.
package vec_agen_pkg;
    // Addressing mode codes as presented on the mode input.
    typedef enum logic [1:0] {
        AM_UNIT   = 2'b00,
        AM_STRIDE = 2'b01,
        AM_INDEX  = 2'b10,
        AM_RSVD   = 2'b11
    } addr_mode_e;
endpackage

// File: rtl/vec_agen_ctrl.sv
// Sequence control: accepts start when idle, captures mode, direction and
// clamped length, counts elements under ready/valid and produces done.
// Assumes start is a level sampled each cycle; it is ignored while busy.
module vec_agen_ctrl
    import vec_agen_pkg::*;
#(
    parameter int MVL = 32,
    parameter int LW  = $clog2(MVL + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [LW-1:0] vl_in,
    input  addr_mode_e mode_in,
    input  logic       dir_in,
    input  logic       out_ready,
    output logic       busy,
    output logic [LW-1:0] elem,
    output logic       last,
    output logic       done,
    output addr_mode_e mode_q,
    output logic       dir_q,
    output logic       load,
    output logic       advance
);
    localparam logic [LW-1:0] MVL_L = LW'(MVL);

    logic          busy_q;
    logic [LW-1:0] elem_q;
    logic [LW-1:0] vl_q;
    logic          done_q;
    logic [LW-1:0] vl_eff;
    logic          accept;
    logic          fin;

    // Clamp the request and decode handshake events.
    always_comb begin
        vl_eff  = (vl_in > MVL_L) ? MVL_L : vl_in;
        accept  = start && !busy_q;
        load    = accept && (vl_eff != '0);
        last    = busy_q && (elem_q == vl_q - LW'(1));
        advance = busy_q && out_ready && !last;
        fin     = busy_q && out_ready && last;
    end

    // Sequence state: busy flag, element counter, captured operands, done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            elem_q <= '0;
            vl_q   <= '0;
            mode_q <= AM_UNIT;
            dir_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= (accept && (vl_eff == '0)) || fin;
            if (load) begin
                busy_q <= 1'b1;
                elem_q <= '0;
                vl_q   <= vl_eff;
                mode_q <= mode_in;
                dir_q  <= dir_in;
            end else if (fin) begin
                busy_q <= 1'b0;
            end else if (advance) begin
                elem_q <= elem_q + LW'(1);
            end
        end
    end

    assign busy = busy_q;
    assign elem = elem_q;
    assign done = done_q;

    // R7: a stalled element keeps its number.
    a_r7_hold_elem: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !out_ready |=> busy_q && $stable(elem_q));
    // R8: start while busy leaves the captured operands alone.
    a_r8_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && start |=> $stable(vl_q) && $stable(mode_q) && $stable(dir_q));
    // R9: zero length gives done next cycle and no sequence.
    a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy_q && (vl_in == '0) |=> done_q && !busy_q);
    // R6: final handshake ends the sequence with a done pulse.
    a_r6_finish: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && out_ready && last |=> done_q && !busy_q);
    // R10: captured length never exceeds MVL.
    a_r10_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> vl_q <= MVL_L && vl_q != '0);
endmodule

// File: rtl/vec_agen_acc.sv
// Running address accumulator: loads base on start and adds the step
// (1 or the captured stride) on each non-final handshake. Also holds the
// captured base for indexed mode. Assumes mode_q is valid whenever advance is.
module vec_agen_acc
    import vec_agen_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  addr_mode_e    mode_q,
    input  logic [AW-1:0] base_in,
    input  logic [AW-1:0] stride_in,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] acc_q
);
    logic [AW-1:0] stride_q;
    logic [AW-1:0] step;

    // Step size for the current mode.
    always_comb step = (mode_q == AM_STRIDE) ? stride_q : AW'(1);

    // Capture operands on load, accumulate on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            stride_q <= '0;
            acc_q    <= '0;
        end else if (load) begin
            base_q   <= base_in;
            stride_q <= stride_in;
            acc_q    <= base_in;
        end else if (advance) begin
            acc_q    <= acc_q + step;
        end
    end

    // R7: with no load and no advance the running address is frozen.
    a_r7_hold_acc: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !advance |=> $stable(acc_q) && $stable(base_q));
endmodule

// File: rtl/vec_agen_sel.sv
// Output address select: indexed mode adds the offset read from the
// index port to the captured base; other modes use the running address.
// HAS_INDEX = 0 builds the block without the indexed adder.
module vec_agen_sel
    import vec_agen_pkg::*;
#(
    parameter int AW        = 32,
    parameter bit HAS_INDEX = 1'b1
) (
    input  addr_mode_e    mode_q,
    input  logic [AW-1:0] base_q,
    input  logic [AW-1:0] acc_q,
    input  logic [AW-1:0] idx_data,
    output logic [AW-1:0] addr
);
    generate
        if (HAS_INDEX) begin : g_idx
            // Choose between base plus offset and the running address.
            always_comb addr = (mode_q == AM_INDEX) ? (base_q + idx_data) : acc_q;
        end else begin : g_noidx
            logic unused_idx;
            // Running address only.
            always_comb begin
                addr       = acc_q;
                unused_idx = ^{idx_data, base_q, mode_q};
            end
        end
    endgenerate
endmodule

// File: rtl/vec_agen.sv
// Vector element address sequencer top. Emits one element address per
// ready/valid handshake for contiguous, strided or indexed modes, then a
// done pulse. Assumes idx_rd_data responds combinationally to idx_rd_addr.
module vec_agen
    import vec_agen_pkg::*;
#(
    parameter int AW  = 32,
    parameter int MVL = 32,
    parameter int LW  = $clog2(MVL + 1),
    parameter int EW  = $clog2(MVL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic          dir,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] stride,
    input  logic [LW-1:0] vl,
    output logic [EW-1:0] idx_rd_addr,
    input  logic [AW-1:0] idx_rd_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [AW-1:0] out_addr,
    output logic [EW-1:0] out_elem,
    output logic          out_last,
    output logic          out_dir,
    output logic          done
);
    addr_mode_e    mode_q;
    logic [LW-1:0] elem;
    logic          load;
    logic          advance;
    logic [AW-1:0] base_q;
    logic [AW-1:0] acc_q;

    vec_agen_ctrl #(.MVL(MVL), .LW(LW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl),
        .mode_in(addr_mode_e'(mode)), .dir_in(dir), .out_ready(out_ready),
        .busy(out_valid), .elem(elem), .last(out_last), .done(done),
        .mode_q(mode_q), .dir_q(out_dir), .load(load), .advance(advance)
    );

    vec_agen_acc #(.AW(AW)) acc_i (
        .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
        .mode_q(mode_q), .base_in(base), .stride_in(stride),
        .base_q(base_q), .acc_q(acc_q)
    );

    vec_agen_sel #(.AW(AW), .HAS_INDEX(1'b1)) sel_i (
        .mode_q(mode_q), .base_q(base_q), .acc_q(acc_q),
        .idx_data(idx_rd_data), .addr(out_addr)
    );

    assign out_elem    = elem[EW-1:0];
    assign idx_rd_addr = elem[EW-1:0];

    // R5: each non-final handshake is followed by the next element.
    a_r5_next_elem: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last |=> out_valid && (out_elem == $past(out_elem) + EW'(1)));
    // R6: done never overlaps a valid element.
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && out_valid));
    // R4: direction stays fixed for the whole sequence.
    a_r4_dir_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !(out_ready && out_last) |=> $stable(out_dir));
endmodule

// File: tb/vec_agen_tb_top.sv
module vec_agen_tb_top;
    localparam int AW  = 32;
    localparam int MVL = 32;
    localparam int LW  = $clog2(MVL + 1);
    localparam int EW  = $clog2(MVL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic          dir = 1'b0;
    logic [AW-1:0] base = '0;
    logic [AW-1:0] stride = '0;
    logic [LW-1:0] vl = '0;
    logic [EW-1:0] idx_rd_addr;
    logic [AW-1:0] idx_rd_data;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [AW-1:0] out_addr;
    logic [EW-1:0] out_elem;
    logic          out_last;
    logic          out_dir;
    logic          done;

    logic [AW-1:0] idx_mem [MVL];
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    // Index register model, combinational read.
    assign idx_rd_data = idx_mem[idx_rd_addr];

    vec_agen #(.AW(AW), .MVL(MVL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .dir(dir),
        .base(base), .stride(stride), .vl(vl),
        .idx_rd_addr(idx_rd_addr), .idx_rd_data(idx_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_elem(out_elem), .out_last(out_last), .out_dir(out_dir), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [1:0] m, input logic [AW-1:0] b,
                                               input logic [AW-1:0] s, input int i);
        case (m)
            2'b01:   return b + AW'(i) * s;
            2'b10:   return b + idx_mem[i];
            default: return b + AW'(i);
        endcase
    endfunction

    // Runs one sequence; the bench is at a negedge on entry and exit.
    task automatic run_seq(input string req, input logic [1:0] m, input bit d,
                           input logic [AW-1:0] b, input logic [AW-1:0] s,
                           input int len, input bit stall, input bit poke);
        int n_exp;
        int cnt;
        int cyc;
        bit rdy;
        n_exp = (len > MVL) ? MVL : len;
        mode = m; dir = d; base = b; stride = s; vl = LW'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // Scramble operand inputs after capture (R4).
        mode = ~m; dir = ~d; base = ~b; stride = s + 7; vl = LW'(3);
        cnt = 0; cyc = 0;
        while (cnt < n_exp && cyc < 2000) begin
            check(out_valid === 1'b1, req, "valid", AW'(out_valid), 1);
            check(out_addr === exp_addr(m, b, s, cnt), req, "addr", out_addr, exp_addr(m, b, s, cnt));
            check(out_elem === EW'(cnt), req, "elem", AW'(out_elem), AW'(cnt));
            check(out_last === (cnt == n_exp - 1), req, "last", AW'(out_last), AW'(cnt == n_exp - 1));
            check(out_dir === d, "R4", "dir", AW'(out_dir), AW'(d));
            check(done === 1'b0, req, "done early", AW'(done), 0);
            rdy = stall ? ((cyc % 3) != 1) : 1'b1;
            out_ready = rdy;
            start = poke && (cyc == 2);  // R8 stimulus: start while busy
            @(negedge clk);
            start = 1'b0;
            if (rdy) cnt++;
            cyc++;
        end
        out_ready = 1'b0;
        check(done === 1'b1, req, "done pulse", AW'(done), 1);
        check(out_valid === 1'b0, req, "valid after end", AW'(out_valid), 0);
        @(negedge clk);
        check(done === 1'b0, req, "done width", AW'(done), 0);
        check(out_valid === 1'b0, req, "idle", AW'(out_valid), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R6", "reset valid", AW'(out_valid), 0);
        check(done === 1'b0, "R6", "reset done", AW'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_unit();      run_seq("R1", 2'b00, 1'b0, 32'h100, 32'h0, 8, 1'b0, 1'b0); endtask
    task automatic t_unit_alt();  run_seq("R1", 2'b11, 1'b1, 32'hFFFF_FFFD, 32'h0, 6, 1'b0, 1'b0); endtask
    task automatic t_stride();    run_seq("R2", 2'b01, 1'b0, 32'h2000, 32'h0000_0010, 12, 1'b0, 1'b0); endtask
    task automatic t_stride_wrap(); run_seq("R2", 2'b01, 1'b1, 32'hFFFF_FF00, 32'h0000_0050, 7, 1'b0, 1'b0); endtask
    task automatic t_stride_neg(); run_seq("R2", 2'b01, 1'b0, 32'h40, 32'hFFFF_FFF8, 5, 1'b0, 1'b0); endtask
    task automatic t_index();     run_seq("R3", 2'b10, 1'b0, 32'h8000, 32'h0, 16, 1'b0, 1'b0); endtask
    task automatic t_store_index(); run_seq("R4", 2'b10, 1'b1, 32'hFFFF_0000, 32'h0, 9, 1'b0, 1'b0); endtask
    task automatic t_stall();     run_seq("R7", 2'b01, 1'b0, 32'h300, 32'h3, 10, 1'b1, 1'b0); endtask
    task automatic t_busy_start(); run_seq("R8", 2'b00, 1'b1, 32'h500, 32'h0, 6, 1'b0, 1'b1); endtask
    task automatic t_single();    run_seq("R5", 2'b01, 1'b0, 32'h77, 32'h9, 1, 1'b1, 1'b0); endtask
    task automatic t_zero();      run_seq("R9", 2'b00, 1'b0, 32'h900, 32'h0, 0, 1'b0, 1'b0); endtask
    task automatic t_full();      run_seq("R5", 2'b00, 1'b0, 32'h0, 32'h0, MVL, 1'b0, 1'b0); endtask
    task automatic t_clamp();     run_seq("R10", 2'b01, 1'b0, 32'h1000, 32'h2, MVL + 5, 1'b0, 1'b0); endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < MVL; i++) idx_mem[i] = AW'((i * 37 + 5) % 211) ^ (i[0] ? 32'hFFFF_FFF0 : 32'h0);
        @(negedge clk);
        t_reset();
        t_unit();
        t_unit_alt();
        t_stride();
        t_stride_wrap();
        t_stride_neg();
        t_index();
        t_store_index();
        t_stall();
        t_busy_start();
        t_single();
        t_zero();
        t_full();
        t_clamp();
        finish_run();
    end

    // Watchdog.
    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule